// File: doc/BRIEF.md
# Load-Cell ADC Serial Responder

This block is a synthesizable model of the converter side of a two-wire weigh-scale ADC link. A host drives a slow serial clock. The model answers on a single data line. It signals when a conversion is waiting, shifts the 24-bit result out on host clock pulses, and counts the extra pulses that follow the data. That count picks the input channel and gain for the conversions that come after it.

A host clock that stays high beyond a set number of system cycles puts the model into power-down. The falling edge that ends power-down resets it to its defaults. Conversion results arrive on a parallel sample port, which stands in for the analog front end. The current channel/gain selection is driven out on a tag port, so that the front end knows which input to convert. The conversion cadence comes from a static rate input and two period parameters given in system-clock cycles.

Top module: `adc_serial_responder`

## Requirements
- R1: While reset is held and right after it, `dout` is 1, `conv_mode` is 0, and `comm_error` and `powered_down` are 0.
- R2: When a conversion period ends with no read in progress, the model captures `sample_value` and drives `dout` to 0 to show that data is ready.
- R3: On each of the first 24 rising edges of the host clock in a cycle, `dout` presents the next bit of the captured value, most significant bit first.
- R4: On rising edges 25 and later in a cycle, `dout` is 1.
- R5: `conv_mode` encodes the selection as 0 = channel A gain 128, 1 = channel B gain 32, 2 = channel A gain 64, and it never takes the value 3. A cycle of 25 pulses sets it to 0 when the next conversion becomes ready.
- R6: A cycle of 26 pulses sets `conv_mode` to 1 when the next conversion becomes ready.
- R7: A cycle of 27 pulses sets `conv_mode` to 2 when the next conversion becomes ready.
- R8: A cycle that has ended with 24 pulses, or with more than 27, raises `comm_error` when its next conversion is due. The flag then stays set, `dout` stays 1 and `conv_mode` is kept, until a power-down release.
- R9: A host clock that stays high for more than `PD_CYCLES` system cycles sets `powered_down` and holds `dout` at 1. Normal clock pulses that are shorter than this do not.
- R10: A falling host clock edge during power-down clears `powered_down` and `comm_error`, sets `conv_mode` to 0 and restarts the conversion timer.
- R11: The conversion period is `FAST_CYCLES` system cycles when `rate_fast` is 1 and `SLOW_CYCLES` when it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk_in | input | 1 | Host serial clock, asynchronous to `clk` |
| rate_fast | input | 1 | Static rate select: 1 selects the fast period, 0 the slow period |
| sample_value | input | 24 | Conversion result presented by the front end |
| dout | output | 1 | Serial data line; 0 means ready, then data bits |
| conv_mode | output | 2 | Channel/gain selection tag for the front end |
| powered_down | output | 1 | High while the model is in power-down |
| comm_error | output | 1 | Sticky flag for an illegal pulse count |

## Verification
Several properties are checked by assertions on every cycle: the error flag is sticky, `dout` is idle-high after the data bits and throughout power-down, the mode tag never takes the unused code, the timer stays within its period, power-down is entered only from a high clock level and left only on a falling edge, and each release restores the defaults. Other behaviour can only be shown by the bench's scenarios. These are the bit order and value of the shifted data, the mapping of each pulse count to a mode tag, the errors raised for 24 and 28 pulses, and the latency of the first ready at each rate setting.

// File: rtl/adc_resp_pkg.sv
package adc_resp_pkg;

  typedef enum logic [1:0] {
    MODE_A128 = 2'd0,
    MODE_B32  = 2'd1,
    MODE_A64  = 2'd2
  } mode_e;

  // extra pulses beyond the data word that select each mode
  localparam int EXTRA_A128 = 1;
  localparam int EXTRA_B32  = 2;
  localparam int EXTRA_A64  = 3;

endpackage

// File: rtl/adc_sclk_edge.sv
module adc_sclk_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk_i,
  output logic lvl_o,
  output logic rise_o,
  output logic fall_o
);

  logic meta_q, sync_q, prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      meta_q <= sclk_i;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  assign lvl_o  = sync_q;
  assign rise_o = sync_q & ~prev_q;
  assign fall_o = ~sync_q & prev_q;

endmodule

// File: rtl/adc_rate_timer.sv
module adc_rate_timer #(
  parameter int SLOW_CYCLES = 12_500_000,
  parameter int FAST_CYCLES = 1_562_500
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fast_i,
  input  logic hold_i,
  input  logic clear_i,
  output logic tick_o
);

  localparam int MAXP = (SLOW_CYCLES > FAST_CYCLES) ? SLOW_CYCLES : FAST_CYCLES;
  localparam int TW   = $clog2(MAXP) + 1;

  logic [TW-1:0] cnt_q, cnt_d, last;
  logic          at_end;

  assign last   = fast_i ? TW'(FAST_CYCLES - 1) : TW'(SLOW_CYCLES - 1);
  assign at_end = (cnt_q >= last);
  assign tick_o = at_end && !hold_i && !clear_i;

  always_comb begin
    cnt_d = cnt_q;
    if (clear_i || hold_i)  cnt_d = '0;
    else if (at_end)        cnt_d = '0;
    else                    cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assert_timer_bound_R11: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= last);

endmodule

// File: rtl/adc_pd_detect.sv
module adc_pd_detect #(
  parameter int PD_CYCLES = 7500
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl_i,
  input  logic fall_i,
  output logic pd_o,
  output logic release_o
);

  localparam int HW = $clog2(PD_CYCLES + 1) + 1;
  localparam logic [HW-1:0] LIMIT = HW'(PD_CYCLES);

  logic [HW-1:0] hcnt_q, hcnt_d;
  logic          pd_q, pd_d;

  assign release_o = pd_q && fall_i;

  always_comb begin
    hcnt_d = hcnt_q;
    if (!lvl_i)               hcnt_d = '0;
    else if (hcnt_q != LIMIT) hcnt_d = hcnt_q + 1'b1;
  end

  always_comb begin
    pd_d = pd_q;
    if (release_o)                     pd_d = 1'b0;
    else if (lvl_i && hcnt_q == LIMIT) pd_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hcnt_q <= '0;
      pd_q   <= 1'b0;
    end else begin
      hcnt_q <= hcnt_d;
      pd_q   <= pd_d;
    end
  end

  assign pd_o = pd_q;

  assert_pd_entry_high_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pd_q) |-> $past(lvl_i));

  assert_pd_exit_fall_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pd_q) |-> $past(fall_i));

endmodule

// File: rtl/adc_shift_core.sv
module adc_shift_core
  import adc_resp_pkg::*;
#(
  parameter int DW = 24,
  parameter int CW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rise_i,
  input  logic          tick_i,
  input  logic          rst_evt_i,
  input  logic          pd_i,
  input  logic [DW-1:0] sample_i,
  output logic          dout_o,
  output mode_e         mode_o,
  output logic          err_o
);

  localparam logic [CW-1:0] CNT_IDLE = '0;
  localparam logic [CW-1:0] CNT_DATA = CW'(DW);
  localparam logic [CW-1:0] CNT_A128 = CW'(DW + EXTRA_A128);
  localparam logic [CW-1:0] CNT_B32  = CW'(DW + EXTRA_B32);
  localparam logic [CW-1:0] CNT_A64  = CW'(DW + EXTRA_A64);

  logic [DW-1:0] shreg_q, shreg_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          dout_q, dout_d;
  logic          err_q, err_d;
  mode_e         mode_q, mode_d;
  logic          in_read;

  assign in_read = (cnt_q != CNT_IDLE) && (cnt_q < CNT_DATA);

  always_comb begin
    shreg_d = shreg_q;
    cnt_d   = cnt_q;
    dout_d  = dout_q;
    mode_d  = mode_q;
    err_d   = err_q;
    if (rst_evt_i) begin
      shreg_d = '0;
      cnt_d   = '0;
      dout_d  = 1'b1;
      mode_d  = MODE_A128;
      err_d   = 1'b0;
    end else if (pd_i || err_q) begin
      dout_d = 1'b1;
    end else if (tick_i && !in_read) begin
      case (cnt_q)
        CNT_IDLE: ;
        CNT_A128: mode_d = MODE_A128;
        CNT_B32:  mode_d = MODE_B32;
        CNT_A64:  mode_d = MODE_A64;
        default:  err_d  = 1'b1;
      endcase
      if (err_d) begin
        dout_d = 1'b1;
      end else begin
        shreg_d = sample_i;
        cnt_d   = '0;
        dout_d  = 1'b0;
      end
    end else if (rise_i) begin
      if (cnt_q != '1) cnt_d = cnt_q + 1'b1;
      if (cnt_q < CNT_DATA) begin
        dout_d  = shreg_q[DW-1];
        shreg_d = {shreg_q[DW-2:0], 1'b0};
      end else begin
        dout_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg_q <= '0;
      cnt_q   <= '0;
      dout_q  <= 1'b1;
      mode_q  <= MODE_A128;
      err_q   <= 1'b0;
    end else begin
      shreg_q <= shreg_d;
      cnt_q   <= cnt_d;
      dout_q  <= dout_d;
      mode_q  <= mode_d;
      err_q   <= err_d;
    end
  end

  assign dout_o = dout_q;
  assign mode_o = mode_q;
  assign err_o  = err_q;

  assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (err_q && !rst_evt_i) |=> err_q);

  assert_tail_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q > CNT_DATA) |-> dout_q);

  assert_mode_legal_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mode_q != mode_e'(2'd3));

endmodule

// File: rtl/adc_serial_responder.sv
module adc_serial_responder
  import adc_resp_pkg::*;
#(
  parameter int DATA_W      = 24,
  parameter int PD_CYCLES   = 7500,
  parameter int SLOW_CYCLES = 12_500_000,
  parameter int FAST_CYCLES = 1_562_500
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_in,
  input  logic              rate_fast,
  input  logic [DATA_W-1:0] sample_value,
  output logic              dout,
  output logic [1:0]        conv_mode,
  output logic              powered_down,
  output logic              comm_error
);

  localparam int CNT_W = $clog2(DATA_W + EXTRA_A64 + 1) + 1;

  logic [1:0] rst_pipe_q;
  logic       rst_int_n;
  logic       sclk_lvl, sclk_rise, sclk_fall;
  logic       pd, pd_release, tick;
  mode_e      mode;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_int_n = rst_pipe_q[1];

  adc_sclk_edge u_edge (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .sclk_i (sclk_in),
    .lvl_o  (sclk_lvl),
    .rise_o (sclk_rise),
    .fall_o (sclk_fall)
  );

  adc_pd_detect #(.PD_CYCLES(PD_CYCLES)) u_pd (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .lvl_i     (sclk_lvl),
    .fall_i    (sclk_fall),
    .pd_o      (pd),
    .release_o (pd_release)
  );

  adc_rate_timer #(.SLOW_CYCLES(SLOW_CYCLES), .FAST_CYCLES(FAST_CYCLES)) u_timer (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .fast_i  (rate_fast),
    .hold_i  (pd),
    .clear_i (pd_release),
    .tick_o  (tick)
  );

  adc_shift_core #(.DW(DATA_W), .CW(CNT_W)) u_core (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .rise_i    (sclk_rise),
    .tick_i    (tick),
    .rst_evt_i (pd_release),
    .pd_i      (pd),
    .sample_i  (sample_value),
    .dout_o    (dout),
    .mode_o    (mode),
    .err_o     (comm_error)
  );

  assign conv_mode    = mode;
  assign powered_down = pd;

  assert_pd_dout_high_R9: assert property (@(posedge clk) disable iff (!rst_int_n)
    pd |=> dout);

  assert_release_defaults_R10: assert property (@(posedge clk) disable iff (!rst_int_n)
    $fell(pd) |-> (conv_mode == 2'd0 && !comm_error));

endmodule

// File: tb/adc_serial_responder_test.sv
module adc_serial_responder_test;

  localparam int PD     = 40;
  localparam int P_SLOW = 2000;
  localparam int P_FAST = 600;
  localparam int HALF   = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sclk_in = 1'b0;
  logic        rate_fast = 1'b1;
  logic [23:0] sample_value = 24'hA5C3F1;
  logic        dout;
  logic [1:0]  conv_mode;
  logic        powered_down;
  logic        comm_error;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  adc_serial_responder #(
    .DATA_W(24), .PD_CYCLES(PD), .SLOW_CYCLES(P_SLOW), .FAST_CYCLES(P_FAST)
  ) uut (
    .clk(clk), .rst_n(rst_n), .sclk_in(sclk_in), .rate_fast(rate_fast),
    .sample_value(sample_value), .dout(dout), .conv_mode(conv_mode),
    .powered_down(powered_down), .comm_error(comm_error)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wait_ready(output int cyc);
    cyc = 0;
    while (dout !== 1'b0 && cyc < 5000) begin
      @(negedge clk);
      cyc++;
    end
  endtask

  task automatic read_frame(input int n, output logic [23:0] data, output bit tail_ok);
    data = '0;
    tail_ok = 1;
    for (int i = 0; i < n; i++) begin
      sclk_in = 1'b1;
      repeat (HALF) @(negedge clk);
      if (i < 24) data = {data[22:0], dout};
      else if (dout !== 1'b1) tail_ok = 0;
      sclk_in = 1'b0;
      repeat (HALF) @(negedge clk);
    end
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    chk(dout === 1'b1, "R1 dout in reset", dout, 1);
    chk(conv_mode === 2'd0 && comm_error === 1'b0 && powered_down === 1'b0,
        "R1 flags in reset", {conv_mode, comm_error, powered_down}, 0);
  endtask

  task automatic t_first_ready_fast;
    int cyc;
    rst_n = 1'b1;
    @(negedge clk);
    chk(dout === 1'b1, "R1 dout after reset", dout, 1);
    wait_ready(cyc);
    cyc++;
    chk(cyc >= P_FAST && cyc <= P_FAST + 8, "R11 fast period", cyc, P_FAST);
    chk(dout === 1'b0, "R2 ready low", dout, 0);
  endtask

  task automatic t_read(input int n, input logic [23:0] exp_data,
                        input logic [23:0] next_val, input logic [1:0] exp_mode,
                        input string req);
    logic [23:0] d;
    bit tail;
    int cyc;
    read_frame(n, d, tail);
    chk(d === exp_data, "R3 data MSB first", d, exp_data);
    chk(tail, "R4 tail pulses high", tail, 1);
    sample_value = next_val;
    wait_ready(cyc);
    chk(dout === 1'b0, "R2 next ready", dout, 0);
    chk(conv_mode === exp_mode, req, conv_mode, exp_mode);
  endtask

  task automatic t_error28;
    logic [23:0] d;
    bit tail;
    read_frame(28, d, tail);
    chk(d === 24'h0F0F0F, "R3 data before error", d, 24'h0F0F0F);
    repeat (P_FAST + 50) @(negedge clk);
    chk(comm_error === 1'b1, "R8 error after 28 pulses", comm_error, 1);
    chk(dout === 1'b1 && conv_mode === 2'd2, "R8 held after error",
        {dout, conv_mode}, 3'b110);
    repeat (P_FAST + 20) @(negedge clk);
    chk(comm_error === 1'b1 && dout === 1'b1, "R8 error sticky", {comm_error, dout}, 3);
  endtask

  task automatic t_powerdown;
    int cyc;
    sclk_in = 1'b1;
    repeat (30) @(negedge clk);
    chk(powered_down === 1'b0, "R9 no power-down yet", powered_down, 0);
    repeat (30) @(negedge clk);
    chk(powered_down === 1'b1, "R9 power-down entered", powered_down, 1);
    chk(dout === 1'b1, "R9 dout high in power-down", dout, 1);
    rate_fast = 1'b0;
    repeat (20) @(negedge clk);
    chk(powered_down === 1'b1, "R9 power-down held", powered_down, 1);
    sclk_in = 1'b0;
    repeat (6) @(negedge clk);
    chk(powered_down === 1'b0 && comm_error === 1'b0 && conv_mode === 2'd0,
        "R10 release defaults", {powered_down, comm_error, conv_mode}, 0);
    wait_ready(cyc);
    cyc += 6;
    chk(cyc >= P_SLOW && cyc <= P_SLOW + 12, "R11 slow period", cyc, P_SLOW);
  endtask

  task automatic t_error24;
    logic [23:0] d;
    bit tail;
    read_frame(24, d, tail);
    chk(d === 24'h3C3C3C, "R3 data 24-pulse read", d, 24'h3C3C3C);
    chk(comm_error === 1'b0, "R8 no error before evaluation", comm_error, 0);
    repeat (P_SLOW + 50) @(negedge clk);
    chk(comm_error === 1'b1 && dout === 1'b1, "R8 error after 24 pulses",
        {comm_error, dout}, 3);
    chk(conv_mode === 2'd0, "R8 mode kept", conv_mode, 0);
  endtask

  initial begin
    t_reset();
    t_first_ready_fast();
    chk(powered_down === 1'b0, "R9 normal pulses no power-down", powered_down, 0);
    t_read(25, 24'hA5C3F1, 24'h123456, 2'd0, "R5 25 pulses A/128");
    t_read(26, 24'h123456, 24'h800001, 2'd1, "R6 26 pulses B/32");
    sample_value = 24'h800001;
    t_read(27, 24'h800001, 24'h0F0F0F, 2'd2, "R7 27 pulses A/64");
    chk(powered_down === 1'b0, "R9 short highs ignored", powered_down, 0);
    t_error28();
    sample_value = 24'h3C3C3C;
    t_powerdown();
    t_error24();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule